// File: doc/BRIEF.md
# Peripheral Register Bus Slave

This block lets a microcontroller reach a small set of peripheral registers over general-purpose port pins. The controller sets a 4-bit register number and a direction bit, where HIGH means read. It then pulls an active-low strobe. On a read, the block puts the selected register on an 8-bit shared data bus for as long as the strobe stays LOW, and releases the bus when the strobe returns HIGH. On a write, the controller places the data on the bus before the strobe falls, and the addressed register takes it in at the first clock edge that sees the strobe LOW.

Behind the bus sit stand-in registers for four peripherals. The card UART has a data byte and a control byte. The clock generator and the power sequencer each have a configuration byte. The auxiliary RAM is reached through a pointer byte and a data window. There is also a read-only status byte that collects interrupt requests from the peripherals. Every peripheral shares a single active-low interrupt line. That line goes HIGH again once the controller has finished reading the status byte. A request that arrives while that read is in progress is not lost.

All bus inputs are taken to be synchronous to the block clock.

Top module: `periph_bus_slave`

## Requirements
- R1: After reset, registers 0 to 6 all read 0x00 and `irq_n` is HIGH.
- R2: The block drives `bus_data` only while `bus_en_n` is LOW and `bus_rw` is HIGH. In that window the read data appears without waiting for a clock edge. At all other times the block leaves the bus undriven.
- R3: A write (`bus_rw` LOW) to register 0 (UART data), 1 (UART control), 2 (clock config) or 3 (sequencer control) is captured at the first rising clock edge that sees `bus_en_n` LOW after it was HIGH. Reading the register back returns the written byte.
- R4: Register 4 is the RAM pointer and reads back all 8 written bits. Register 5 reads and writes RAM entry `ptr mod RAM_DEPTH`, so only the low log2(RAM_DEPTH) pointer bits select the entry.
- R5: Addresses 7 to 15 read as 0x00, and writes to them change no register.
- R6: Register 6 is the status byte. Bit i is HIGH while source i (`src_evt[i]`) is pending, and the bits above NSRC-1 read 0. A write to register 6 is ignored.
- R7: A source sampled HIGH at a rising edge becomes pending at that edge. `irq_n` is LOW from that edge on while any source is pending.
- R8: When a status read ends (`bus_en_n` rises), the clock edge that sees the rise clears every bit that was pending when the read began. `irq_n` goes HIGH at that edge if no other bit is pending.
- R9: A source that becomes pending while a status read is in progress stays pending after the read ends, and `irq_n` stays LOW.
- R10: Reading any register other than 6, or writing any register, leaves pending bits and `irq_n` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_en_n | input | 1 | Access strobe, active low |
| bus_rw | input | 1 | Direction: 1 = read, 0 = write |
| bus_addr | input | 4 | Register number |
| bus_data | inout | 8 | Shared data bus |
| src_evt | input | NSRC | Peripheral interrupt requests, sampled each clock |
| irq_n | output | 1 | Shared interrupt line, active low |

## Verification
Read data depends only on the strobe and the current register values. The bench therefore samples it 1 ns after lowering the strobe, and checks that the bus is released by driving a probe value 1 ns after the strobe rises. The strobe falls at a falling clock edge, so a write lands at the next rising edge, and the bench reads it back one full access later. A source pulse set at a falling edge is pending at the next rising edge, so `irq_n` is checked at the falling edge after that. A status read's clear happens at the rising edge after the strobe returns HIGH, so each read task ends on the falling edge after that rise before `irq_n` is compared.

// File: rtl/periph_bus_pkg.sv
package periph_bus_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [ADDR_W-1:0] {
        RA_UART_DATA = 4'd0,
        RA_UART_CTL  = 4'd1,
        RA_CLK_CFG   = 4'd2,
        RA_SEQ_CTL   = 4'd3,
        RA_RAM_PTR   = 4'd4,
        RA_RAM_WIN   = 4'd5,
        RA_STATUS    = 4'd6
    } reg_addr_e;

    // One select line per implemented register; all low for unused numbers.
    typedef struct packed {
        logic uart_data;
        logic uart_ctl;
        logic clk_cfg;
        logic seq_ctl;
        logic ram_ptr;
        logic ram_win;
        logic status;
    } reg_sel_t;

    // Strobe events seen at one clock edge.
    typedef struct packed {
        logic fall;
        logic rise;
    } strobe_ev_t;

    function automatic reg_sel_t decode_addr(input addr_t a);
        reg_sel_t s;
        s = '0;
        case (a)
            RA_UART_DATA: s.uart_data = 1'b1;
            RA_UART_CTL:  s.uart_ctl  = 1'b1;
            RA_CLK_CFG:   s.clk_cfg   = 1'b1;
            RA_SEQ_CTL:   s.seq_ctl   = 1'b1;
            RA_RAM_PTR:   s.ram_ptr   = 1'b1;
            RA_RAM_WIN:   s.ram_win   = 1'b1;
            RA_STATUS:    s.status    = 1'b1;
            default:      s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/periph_addr_decode.sv
module periph_addr_decode
    import periph_bus_pkg::*;
(
    input  addr_t    addr,
    output reg_sel_t sel
);

    always_comb sel = decode_addr(addr);

endmodule

// File: rtl/periph_reg_bank.sv
module periph_reg_bank
    import periph_bus_pkg::*;
#(
    parameter int RAM_DEPTH = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_stb,
    input  reg_sel_t sel,
    input  byte_t    wdata,
    input  byte_t    status_val,
    output byte_t    rdata
);

    localparam int IDX_W = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1;

    byte_t uart_data_q;
    byte_t uart_ctl_q;
    byte_t clk_cfg_q;
    byte_t seq_ctl_q;
    byte_t ram_ptr_q;
    byte_t ram_q [RAM_DEPTH];

    logic [IDX_W-1:0] ram_idx;
    assign ram_idx = ram_ptr_q[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            uart_data_q <= '0;
            uart_ctl_q  <= '0;
            clk_cfg_q   <= '0;
            seq_ctl_q   <= '0;
            ram_ptr_q   <= '0;
            for (int i = 0; i < RAM_DEPTH; i++) ram_q[i] <= '0;
        end else if (wr_stb) begin
            if (sel.uart_data) uart_data_q <= wdata;
            if (sel.uart_ctl)  uart_ctl_q  <= wdata;
            if (sel.clk_cfg)   clk_cfg_q   <= wdata;
            if (sel.seq_ctl)   seq_ctl_q   <= wdata;
            if (sel.ram_ptr)   ram_ptr_q   <= wdata;
            if (sel.ram_win)   ram_q[ram_idx] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if      (sel.uart_data) rdata = uart_data_q;
        else if (sel.uart_ctl)  rdata = uart_ctl_q;
        else if (sel.clk_cfg)   rdata = clk_cfg_q;
        else if (sel.seq_ctl)   rdata = seq_ctl_q;
        else if (sel.ram_ptr)   rdata = ram_ptr_q;
        else if (sel.ram_win)   rdata = ram_q[ram_idx];
        else if (sel.status)    rdata = status_val;
    end

endmodule

// File: rtl/periph_irq_ctrl.sv
module periph_irq_ctrl #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_evt,
    input  logic            rd_start_stat,
    input  logic            rd_end_stat,
    output logic [NSRC-1:0] pend,
    output logic [NSRC-1:0] snap,
    output logic            irq_n
);

    logic [NSRC-1:0] kept;

    // Only the bits shown when the read began are retired at its end.
    assign kept = rd_end_stat ? (pend & ~snap) : pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= '0;
            snap <= '0;
        end else begin
            pend <= kept | src_evt;
            if (rd_start_stat) snap <= pend;
        end
    end

    assign irq_n = ~(|pend);

endmodule

// File: rtl/periph_bus_slave.sv
module periph_bus_slave
    import periph_bus_pkg::*;
#(
    parameter int NSRC      = 4,
    parameter int RAM_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en_n,
    input  logic              bus_rw,
    input  logic [ADDR_W-1:0] bus_addr,
    inout  wire  [DATA_W-1:0] bus_data,
    input  logic [NSRC-1:0]   src_evt,
    output logic              irq_n
);

    reg_sel_t        sel;
    strobe_ev_t      ev;
    logic            en_q;
    logic            stat_rd_q;
    logic            wr_stb;
    logic            rd_start_stat;
    logic            rd_end_stat;
    byte_t           rd_mux;
    byte_t           status_val;
    logic [NSRC-1:0] pend;
    logic [NSRC-1:0] snap;

    periph_addr_decode u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q      <= 1'b1;
            stat_rd_q <= 1'b0;
        end else begin
            en_q <= bus_en_n;
            if (rd_start_stat)  stat_rd_q <= 1'b1;
            else if (ev.rise)   stat_rd_q <= 1'b0;
        end
    end

    assign ev.fall       = en_q & ~bus_en_n;
    assign ev.rise       = ~en_q & bus_en_n;
    assign wr_stb        = ev.fall & ~bus_rw;
    assign rd_start_stat = ev.fall & bus_rw & sel.status;
    assign rd_end_stat   = ev.rise & stat_rd_q;

    always_comb begin
        status_val = '0;
        status_val[NSRC-1:0] = pend;
    end

    periph_reg_bank #(.RAM_DEPTH(RAM_DEPTH)) u_bank (
        .clk        (clk),
        .rst        (rst),
        .wr_stb     (wr_stb),
        .sel        (sel),
        .wdata      (bus_data),
        .status_val (status_val),
        .rdata      (rd_mux)
    );

    periph_irq_ctrl #(.NSRC(NSRC)) u_irq (
        .clk           (clk),
        .rst           (rst),
        .src_evt       (src_evt),
        .rd_start_stat (rd_start_stat),
        .rd_end_stat   (rd_end_stat),
        .pend          (pend),
        .snap          (snap),
        .irq_n         (irq_n)
    );

    assign bus_data = (!bus_en_n && bus_rw) ? rd_mux : {DATA_W{1'bz}};

endmodule

// File: rtl/periph_bus_checker.sv
module periph_bus_checker
    import periph_bus_pkg::*;
#(
    parameter int NSRC = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_en_n,
    input logic              bus_rw,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NSRC-1:0]   src_evt,
    input logic              irq_n,
    input byte_t             rd_mux,
    input logic [NSRC-1:0]   pend,
    input logic [NSRC-1:0]   snap,
    input logic              rd_end_stat
);

    // R1: the interrupt line is released coming out of reset
    p_reset_irq_high_r1: assert property (@(posedge clk)
        rst |=> irq_n);

    // R5: unused register numbers present zero on a read
    p_unused_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (!bus_en_n && bus_rw && bus_addr > ADDR_W'(RA_STATUS)) |-> rd_mux == '0);

    // R6: status bits above the source count read zero
    p_status_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (!bus_en_n && bus_rw && bus_addr == ADDR_W'(RA_STATUS)) |-> (rd_mux >> NSRC) == '0);

    // R7: a sampled source pulls the line low at the next edge
    p_src_raises_irq_r7: assert property (@(posedge clk) disable iff (rst)
        (|src_evt) |=> !irq_n);

    // R8: bits shown at the start of a status read are gone after it ends
    p_status_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_end_stat && ((src_evt & snap) == '0)) |=> ((pend & $past(snap)) == '0));

    // R9 / R10: outside the end of a status read no pending bit is lost
    p_pend_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !rd_end_stat |=> ((pend & $past(pend)) == $past(pend)));

endmodule

bind periph_bus_slave periph_bus_checker #(.NSRC(NSRC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_en_n    (bus_en_n),
    .bus_rw      (bus_rw),
    .bus_addr    (bus_addr),
    .src_evt     (src_evt),
    .irq_n       (irq_n),
    .rd_mux      (rd_mux),
    .pend        (pend),
    .snap        (snap),
    .rd_end_stat (rd_end_stat)
);

// File: tb/tb_periph_bus_slave.sv
module tb_periph_bus_slave;

    localparam int NSRC  = 4;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_n = 1'b1;
    logic       rw = 1'b1;
    logic [3:0] addr = '0;
    logic [NSRC-1:0] src = '0;
    logic       drv_en = 1'b0;
    logic [7:0] drv_val = '0;
    wire  [7:0] bus_data;
    wire        irq_n;

    int checks = 0;
    int failures = 0;

    assign bus_data = drv_en ? drv_val : 8'hzz;

    always #4 clk = ~clk;

    periph_bus_slave #(.NSRC(NSRC), .RAM_DEPTH(DEPTH)) dut (
        .clk      (clk),
        .rst      (rst),
        .bus_en_n (en_n),
        .bus_rw   (rw),
        .bus_addr (addr),
        .bus_data (bus_data),
        .src_evt  (src),
        .irq_n    (irq_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; rw = 1'b0; drv_val = d; drv_en = 1'b1; en_n = 1'b0;
        @(negedge clk);
        en_n = 1'b1; drv_en = 1'b0; rw = 1'b1;
    endtask

    // Ends on the falling edge after the edge that registers the strobe rise.
    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rw = 1'b1; en_n = 1'b0;
        #1 v = bus_data;
        @(negedge clk);
        en_n = 1'b1;
        @(negedge clk);
    endtask

    // With the strobe HIGH, a probe value from the bench must come through untouched.
    task automatic probe_idle(input string req, input logic [7:0] pv);
        #1 drv_val = pv; drv_en = 1'b1;
        #1 check(req, bus_data, pv);
        drv_en = 1'b0;
    endtask

    task automatic pulse_src(input logic [NSRC-1:0] s);
        @(negedge clk);
        src = s;
        @(negedge clk);
        src = '0;
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 17) ^ 90);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 irq_n after reset", {7'd0, irq_n}, 8'h01);
        for (int a = 0; a < 7; a++) begin
            rd(4'(a), v);
            check($sformatf("R1 reg%0d reset", a), v, 8'h00);
        end
        probe_idle("R2 bus released after read", 8'hA5);

        // R3 R4 R5 R6: write every address, then read every address
        for (int a = 0; a < 16; a++) wr(4'(a), pat(a));
        for (int a = 0; a < 16; a++) begin
            logic [7:0] e;
            rd(4'(a), v);
            if (a <= 5)      e = pat(a);
            else             e = 8'h00;
            if (a <= 3)      check($sformatf("R3 reg%0d readback", a), v, e);
            else if (a <= 5) check($sformatf("R4 reg%0d readback", a), v, e);
            else if (a == 6) check("R6 status write ignored", v, e);
            else             check($sformatf("R5 unused reg%0d", a), v, e);
        end

        // R2: the bench's write data stays on the bus during a write strobe
        @(negedge clk);
        addr = 4'd0; rw = 1'b0; drv_val = 8'h3C; drv_en = 1'b1; en_n = 1'b0;
        #1 check("R2 no drive during write", bus_data, 8'h3C);
        @(negedge clk);
        en_n = 1'b1; drv_en = 1'b0; rw = 1'b1;
        probe_idle("R2 bus released after write", 8'h96);

        // R4: RAM sweep with aliasing upper pointer bits
        for (int i = 0; i < DEPTH; i++) begin
            wr(4'd4, 8'(i + 16 * (i % 3)));
            wr(4'd5, 8'(8'h80 ^ (i * 7)));
        end
        for (int i = 0; i < DEPTH; i++) begin
            logic [7:0] p;
            p = 8'(i + 16 * ((i + 1) % 5));
            wr(4'd4, p);
            rd(4'd4, v);
            check($sformatf("R4 ptr readback %0d", i), v, p);
            rd(4'd5, v);
            check($sformatf("R4 ram entry %0d", i), v, 8'(8'h80 ^ (i * 7)));
        end

        // R7 R8: each source alone
        for (int i = 0; i < NSRC; i++) begin
            pulse_src(NSRC'(1 << i));
            check($sformatf("R7 irq low src%0d", i), {7'd0, irq_n}, 8'h00);
            rd(4'd6, v);
            check($sformatf("R6 status src%0d", i), v, 8'(1 << i));
            check($sformatf("R8 irq released src%0d", i), {7'd0, irq_n}, 8'h01);
        end

        // R6 R8: two sources together
        pulse_src(4'b0101);
        rd(4'd6, v);
        check("R6 status two sources", v, 8'h05);
        check("R8 irq released two sources", {7'd0, irq_n}, 8'h01);
        rd(4'd6, v);
        check("R8 status empty after read", v, 8'h00);

        // R9: a source arrives while the status read is in progress
        pulse_src(4'b0010);
        @(negedge clk);
        addr = 4'd6; rw = 1'b1; en_n = 1'b0;
        #1 v = bus_data;
        check("R9 status at read start", v, 8'h02);
        src = 4'b1000;
        @(negedge clk);
        src = '0; en_n = 1'b1;
        @(negedge clk);
        check("R9 irq still low", {7'd0, irq_n}, 8'h00);
        rd(4'd6, v);
        check("R9 late source kept", v, 8'h08);
        check("R9 irq released after second read", {7'd0, irq_n}, 8'h01);

        // R10: other reads and writes leave a pending source alone
        pulse_src(4'b0001);
        rd(4'd0, v);
        check("R10 irq after other read", {7'd0, irq_n}, 8'h00);
        wr(4'd6, 8'hFF);
        check("R10 irq after status write", {7'd0, irq_n}, 8'h00);
        rd(4'd6, v);
        check("R10 status unchanged", v, 8'h01);
        check("R8 irq released", {7'd0, irq_n}, 8'h01);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule